// File: doc/BRIEF.md
# I2C Read-Target Transmitter with Clock Stretching

This block is the transmit side of an I2C target. It watches the bus for a start condition, collects the 7-bit address and direction bit, and answers only a read aimed at its fixed address. It then serves bytes to the controller: each byte goes out MSB first, SDA is released for the acknowledge clock, and the controller's ACK or NACK is sampled on the rising edge of that ninth clock.

Between bytes the target holds SCL low until local firmware acts. Writing a byte through `wr_valid`/`wr_data` loads it and ends the stretch. Pulsing `rel_req` instead also ends the stretch, but it drops the transmit flag and the target drives nothing more until the next start. After a NACK the target sends nothing further, so only `rel_req` can free SCL. A one-cycle `irq_xfer` marks the end of the address phase and the end of every byte. A one-cycle `irq_stop` marks a stop condition.

The controller is a state machine with eight states:
- `ST_IDLE`: the bus is idle.
- `ST_ADDR`: the address byte is being shifted in.
- `ST_ADDR_ACK`: the target pulls SDA low for the ninth clock.
- `ST_HOLD`: SCL is stretched while the target waits for firmware.
- `ST_LOAD`: SCL is still held while the first bit settles on SDA.
- `ST_SEND`: data bits are being shifted out.
- `ST_ACK_CHK`: SDA is released and the controller's response is sampled.
- `ST_DONE`: the target stays silent until the next start.

Transitions:
- A start from any state goes to `ST_ADDR`. A stop from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a read hit, and to `ST_DONE` on an address miss or a write request. This happens on the falling edge of SCL after the eighth bit.
- `ST_ADDR_ACK` and `ST_ACK_CHK` go to `ST_HOLD` on the falling edge of the ninth clock.
- `ST_HOLD` goes to `ST_LOAD` on a data write when the last response was an ACK, and to `ST_DONE` on `rel_req`.
- `ST_LOAD` goes to `ST_SEND` once the setup count expires.
- `ST_SEND` goes to `ST_ACK_CHK` on the eighth falling edge.

Top module: `i2cst_slave_tx`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `tx_mode`, `ack_det`, `irq_xfer` and `irq_stop` are all 0.
- R2: An address byte equal to `OWN_ADDR` in bits 7..1, with bit 0 = 1 (read), makes the target drive SDA low during the ninth clock and sets `tx_mode`. Any other address, or bit 0 = 0, gets no acknowledge, no interrupt and no SCL hold.
- R3: On the falling edge of the ninth clock of the address byte and of every transmitted byte, the target pulses `irq_xfer` for one cycle and holds SCL low. The hold lasts until `wr_valid` or `rel_req`.
- R4: A data write while holding after an ACK sends that byte MSB first, and SDA changes only while SCL is low.
- R5: SDA is released for the acknowledge clock. `ack_det` becomes 1 when SDA is low at the rising edge of the ninth clock, stays 0 on a NACK, and clears when a new byte is loaded.
- R6: After a NACK, data writes are ignored and SCL stays held. `rel_req` then releases SCL.
- R7: `rel_req` while holding clears `tx_mode` and releases SCL. The target then drives SDA no more, so a controller reading on reads 8'hFF.
- R8: SDA rising while SCL is high pulses `irq_stop` for one cycle and clears `tx_mode`.
- R9: SDA falling while SCL is high restarts address reception from bit 0, even in the middle of an address byte.
- R10: After a data write, SCL stays low for at least `SETUP_CYCLES` clock cycles with the byte's MSB already on SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_valid | input | 1 | One-cycle strobe: next byte to send |
| wr_data | input | DATA_W | Byte to send |
| rel_req | input | 1 | One-cycle strobe: release stretch without data |
| irq_xfer | output | 1 | One-cycle pulse at end of address or byte |
| irq_stop | output | 1 | One-cycle pulse on stop condition |
| ack_det | output | 1 | Controller acknowledged the last byte |
| tx_mode | output | 1 | Target is in transmit direction |

## Verification
The bench goes after the NACK-then-write case. A design that treated the write as usual would free SCL and push an extra byte onto a controller that has already declined it. It probes SCL and the bus data after a plain release: a design that kept `tx_mode` set or kept driving SDA would corrupt the controller's next read, which must return all ones. A repeated start in the middle of an address byte catches a bit counter that does not rewind, which would misread the address and leave the controller unacknowledged. The bench also measures the setup time after each data write, where a design that freed SCL together with its first SDA change would let the controller sample a stale bit.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HOLD,
        ST_LOAD,
        ST_SEND,
        ST_ACK_CHK,
        ST_DONE
    } tx_state_e;

endpackage

// File: rtl/i2cst_bus_monitor.sv
module i2cst_bus_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic scl_p, sda_p, scl_s;

    // Synchronizer chain; the bus idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q[0] <= scl_i;
            sda_q[0] <= sda_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                scl_q[i] <= scl_q[i-1];
                sda_q[i] <= sda_q[i-1];
            end
            scl_p <= scl_q[SYNC_STAGES-1];
            sda_p <= sda_q[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_q[SYNC_STAGES-1];
    assign sda_s     = sda_q[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cst_shifter.sv
module i2cst_shifter #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic          clr,
    input  logic          shift_en,
    input  logic          shift_bit,
    output logic [W-1:0]  data_q,
    output logic [CW-1:0] cnt_q
);

    // One register serves both directions: address bits shift in at the LSB,
    // transmit bits leave at the MSB
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            data_q <= load_val;
            cnt_q  <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
        end else if (shift_en) begin
            data_q <= {data_q[W-2:0], shift_bit};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2cst_slave_tx.sv
module i2cst_slave_tx
    import i2cst_pkg::*;
#(
    parameter int          DATA_W       = 8,
    parameter logic [6:0]  OWN_ADDR     = 7'h42,
    parameter int          SYNC_STAGES  = 2,
    parameter int          SETUP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rel_req,
    output logic              irq_xfer,
    output logic              irq_stop,
    output logic              ack_det,
    output logic              tx_mode
);

    localparam int CNT_W   = $clog2(DATA_W + 1);
    localparam int SETUP_W = $clog2(SETUP_CYCLES + 1);

    tx_state_e st, nxt;

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              sh_load, sh_clr, sh_shift, sh_bit;
    logic [DATA_W-1:0] sh_data;
    logic [CNT_W-1:0]  sh_cnt;
    logic [SETUP_W-1:0] setup_cnt;
    logic              nack_q, addr_hit, setup_done;

    i2cst_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) mon_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cst_shifter #(.W(DATA_W), .CW(CNT_W)) shf_i (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(wr_data),
        .clr(sh_clr), .shift_en(sh_shift), .shift_bit(sh_bit),
        .data_q(sh_data), .cnt_q(sh_cnt)
    );

    assign addr_hit   = (sh_data[DATA_W-1:1] == OWN_ADDR) && sh_data[0];
    assign setup_done = (setup_cnt == SETUP_W'(SETUP_CYCLES - 1));

    // Next-state logic
    always_comb begin
        nxt      = st;
        sh_load  = 1'b0;
        sh_clr   = 1'b0;
        sh_shift = 1'b0;
        sh_bit   = 1'b0;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt    = ST_ADDR;
            sh_clr = 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh_shift = 1'b1;
                        sh_bit   = sda_s;
                    end else if (scl_fall && sh_cnt == CNT_W'(DATA_W)) begin
                        nxt = addr_hit ? ST_ADDR_ACK : ST_DONE;
                    end
                end
                ST_ADDR_ACK: if (scl_fall) nxt = ST_HOLD;
                ST_HOLD: begin
                    if (wr_valid && !nack_q) begin
                        nxt     = ST_LOAD;
                        sh_load = 1'b1;
                    end else if (rel_req) begin
                        nxt = ST_DONE;
                    end
                end
                ST_LOAD: if (setup_done) nxt = ST_SEND;
                ST_SEND: begin
                    if (scl_fall) begin
                        sh_shift = 1'b1;
                        if (sh_cnt == CNT_W'(DATA_W - 1)) nxt = ST_ACK_CHK;
                    end
                end
                ST_ACK_CHK: if (scl_fall) nxt = ST_HOLD;
                ST_DONE: ;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Flags, interrupts and setup timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_xfer  <= 1'b0;
            irq_stop  <= 1'b0;
            ack_det   <= 1'b0;
            nack_q    <= 1'b0;
            tx_mode   <= 1'b0;
            setup_cnt <= '0;
        end else begin
            irq_xfer  <= (nxt == ST_HOLD) && (st != ST_HOLD);
            irq_stop  <= stop_det;
            setup_cnt <= (st == ST_LOAD) ? setup_cnt + 1'b1 : '0;
            if (start_det || stop_det) begin
                tx_mode <= 1'b0;
                ack_det <= 1'b0;
                nack_q  <= 1'b0;
            end else begin
                if (st == ST_ADDR_ACK && nxt == ST_HOLD) tx_mode <= 1'b1;
                if (st == ST_HOLD && nxt == ST_DONE)     tx_mode <= 1'b0;
                if (sh_load) begin
                    ack_det <= 1'b0;
                    nack_q  <= 1'b0;
                end else if (st == ST_ACK_CHK && scl_rise) begin
                    ack_det <= ~sda_s;
                    nack_q  <= sda_s;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        scl_oe = (st == ST_HOLD) || (st == ST_LOAD);
        sda_oe = (st == ST_ADDR_ACK) ||
                 (((st == ST_LOAD) || (st == ST_SEND)) && !sh_data[DATA_W-1]);
    end

endmodule

// File: rtl/i2cst_slave_tx_chk.sv
module i2cst_slave_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic wr_valid,
    input logic rel_req,
    input logic irq_xfer,
    input logic irq_stop,
    input logic ack_det,
    input logic tx_mode
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!scl_oe && !sda_oe && !tx_mode && !ack_det));

    p_xfer_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_xfer |=> !irq_xfer);

    p_xfer_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_xfer |-> scl_oe);

    p_hold_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_xfer && !wr_valid && !rel_req) |=> scl_oe);

    p_sda_moves_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    p_ack_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_det) |-> !sda_oe);

    p_release_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_mode) && !irq_stop) |-> !scl_oe);

    p_stop_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stop |=> !irq_stop);

    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stop |-> !tx_mode);

endmodule

bind i2cst_slave_tx i2cst_slave_tx_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .rel_req(rel_req), .irq_xfer(irq_xfer),
    .irq_stop(irq_stop), .ack_det(ack_det), .tx_mode(tx_mode)
);

// File: tb/i2cst_slave_tx_tb_top.sv
module i2cst_slave_tx_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 8;
    localparam logic [6:0] OWN        = 7'h42;
    localparam int         SETUP      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_oe, sda_oe, scl_line, sda_line;
    logic wr_valid = 1'b0, rel_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic irq_xfer, irq_stop, ack_det, tx_mode;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    i2cst_slave_tx #(.DATA_W(8), .OWN_ADDR(OWN), .SYNC_STAGES(2), .SETUP_CYCLES(SETUP)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_data(wr_data),
        .rel_req(rel_req), .irq_xfer(irq_xfer), .irq_stop(irq_stop),
        .ack_det(ack_det), .tx_mode(tx_mode)
    );

    int n_chk = 0, n_fail = 0;
    int irq_x_cnt = 0, irq_s_cnt = 0;

    always @(posedge clk) begin
        if (irq_xfer) irq_x_cnt++;
        if (irq_stop) irq_s_cnt++;
    end

    function automatic bit exp_ack_bit(input logic [6:0] a, input bit rw);
        return (a == OWN && rw) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] v, input bit released);
        return released ? 8'hFF : v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        int t = 0;
        while (!scl_line && t < 4000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 4000) check(0, "R3", "stretch never released", 0, 1);
    endtask

    task automatic pulse(output bit b);
        m_scl = 1'b1;
        wait_scl_high();
        step(Q);
        b = sda_line;
        step(Q);
        m_scl = 1'b0;
        step(Q);
    endtask

    task automatic put_bit(input bit v);
        bit d;
        m_sda = v;
        step(Q);
        pulse(d);
    endtask

    task automatic m_start();
        m_scl = 1'b0; step(Q);
        m_sda = 1'b1; step(Q);
        m_scl = 1'b1; wait_scl_high(); step(Q);
        m_sda = 1'b0; step(Q);
        m_scl = 1'b0; step(Q);
    endtask

    task automatic m_stop();
        m_scl = 1'b0; step(Q);
        m_sda = 1'b0; step(Q);
        m_scl = 1'b1; wait_scl_high(); step(Q);
        m_sda = 1'b1; step(Q);
    endtask

    task automatic send_addr(input logic [6:0] a, input bit rw, output bit ack);
        for (int i = 6; i >= 0; i--) put_bit(a[i]);
        put_bit(rw);
        m_sda = 1'b1;
        pulse(ack);
    endtask

    task automatic read_byte(output logic [7:0] d, input bit give_ack);
        bit b;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            pulse(b);
            d[i] = b;
        end
        m_sda = !give_ack;
        pulse(b);
        m_sda = 1'b1;
    endtask

    task automatic sw_wr(input logic [7:0] v);
        wr_data = v; wr_valid = 1'b1; step(1); wr_valid = 1'b0;
    endtask

    task automatic sw_rel();
        rel_req = 1'b1; step(1); rel_req = 1'b0;
    endtask

    task automatic hold_check(input string req);
        m_scl = 1'b1;
        step(20);
        check(scl_line == 1'b0, req, "SCL stretched", scl_line, 0);
    endtask

    // One read transaction; end_nack picks NACK on the last byte versus release
    task automatic read_txn(input logic [6:0] a, input int nb, input bit end_nack,
                            input bit probe_after);
        bit ack, give;
        int x0, s0, n;
        logic [7:0] v, d;
        x0 = irq_x_cnt;
        m_start();
        send_addr(a, 1'b1, ack);
        check(ack == exp_ack_bit(a, 1'b1), "R2", "address acknowledge", ack, exp_ack_bit(a, 1'b1));
        step(4);
        if (exp_ack_bit(a, 1'b1)) begin
            check(irq_x_cnt == x0, "R2", "no irq on miss", irq_x_cnt - x0, 0);
            check(tx_mode == 1'b0, "R2", "tx_mode on miss", tx_mode, 0);
        end else begin
            check(irq_x_cnt == x0 + 1, "R3", "irq after address", irq_x_cnt - x0, 1);
            check(tx_mode == 1'b1, "R2", "tx_mode after hit", tx_mode, 1);
            for (int k = 0; k < nb; k++) begin
                hold_check("R3");
                v = 8'($urandom);
                sw_wr(v);
                check(ack_det == 1'b0, "R5", "ack_det cleared on load", ack_det, 0);
                n = 1;
                while (!scl_line && n < 1000) begin step(1); n++; end
                check(n >= SETUP, "R10", "setup cycles", n, SETUP);
                check(sda_line == v[7], "R10", "MSB on SDA at release", sda_line, v[7]);
                give = !(end_nack && k == nb - 1);
                read_byte(d, give);
                check(d == exp_read(v, 1'b0), "R4", "byte read", d, v);
                step(4);
                check(ack_det == give, "R5", "ack_det after response", ack_det, give);
                check(irq_x_cnt == x0 + 2 + k, "R3", "irq per byte", irq_x_cnt - x0, 2 + k);
            end
            hold_check(end_nack ? "R6" : "R3");
            if (end_nack) begin
                sw_wr(8'h00);
                step(40);
                check(scl_line == 1'b0, "R6", "write after NACK ignored", scl_line, 0);
            end
            sw_rel();
            step(6);
            check(scl_line == 1'b1, end_nack ? "R6" : "R7", "SCL freed by release", scl_line, 1);
            check(tx_mode == 1'b0, "R7", "tx_mode cleared by release", tx_mode, 0);
            if (probe_after) begin
                m_scl = 1'b0; step(Q);
                read_byte(d, 1'b0);
                check(d == exp_read(8'h00, 1'b1), "R7", "nothing driven after release", d, 8'hFF);
            end
        end
        s0 = irq_s_cnt;
        m_stop();
        step(4);
        check(irq_s_cnt == s0 + 1, "R8", "stop interrupt", irq_s_cnt - s0, 1);
        check(tx_mode == 1'b0, "R8", "tx_mode after stop", tx_mode, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        bit ack;
        int x0;
        logic [6:0] a;
        void'($urandom(32'd20240611));
        step(4);
        check(!scl_oe && !sda_oe, "R1", "lines quiet in reset", {scl_oe, sda_oe}, 0);
        rst_n = 1'b1;
        step(3);
        check({scl_oe, sda_oe, tx_mode, ack_det, irq_xfer, irq_stop} == 6'b0, "R1",
              "outputs after reset", {scl_oe, sda_oe, tx_mode, ack_det, irq_xfer, irq_stop}, 0);

        // Write direction to own address: no acknowledge
        x0 = irq_x_cnt;
        m_start();
        send_addr(OWN, 1'b0, ack);
        check(ack == exp_ack_bit(OWN, 1'b0), "R2", "write direction ignored", ack, 1);
        step(4);
        check(irq_x_cnt == x0 && !tx_mode, "R2", "no irq for write", irq_x_cnt - x0, 0);
        m_stop();

        // Directed: release path followed by an extra read
        read_txn(OWN, 2, 1'b0, 1'b1);
        // Directed: NACK on the first byte
        read_txn(OWN, 1, 1'b1, 1'b0);
        // Directed: address miss
        read_txn(OWN ^ 7'h01, 1, 1'b0, 1'b0);

        // R9: repeated start in the middle of the address byte
        m_start();
        put_bit(OWN[6]); put_bit(OWN[5]); put_bit(OWN[4]);
        m_start();
        send_addr(OWN, 1'b1, ack);
        check(ack == 1'b0, "R9", "address after repeated start", ack, 0);
        step(4);
        check(tx_mode == 1'b1, "R9", "tx_mode after repeated start", tx_mode, 1);
        hold_check("R9");
        sw_rel();
        step(6);
        m_stop();
        step(4);

        // Random transactions
        for (int t = 0; t < 10; t++) begin
            if ($urandom % 4 == 0) a = OWN ^ 7'($urandom_range(1, 127));
            else                   a = OWN;
            read_txn(a, 1 + int'($urandom % 3), bit'($urandom % 2), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule